// File: doc/BRIEF.md
# Multi-Mode DAC Code Input Controller

This block chooses and holds the 8-bit code that feeds a digital-to-analog converter. The code can come from one of four places. It can be an 8-bit parallel bus captured when chip-select rises. It can be a serial byte committed when chip-select rises (SPI use). It can be a serial byte committed by an update strobe from a test-access controller. Or it can be a value held in nonvolatile storage, which arrives here as a plain register input. The test-access state machine and the nonvolatile programming are not part of the block; only their strobes and the stored value come in.

Two pins and one configuration bit pick the mode, with a fixed priority. The parallel and serial input latches reset to mid-scale, so the converter output sits at its centre until new data is committed. The serial shifter also drives a serial data output, and a separate enable says when that output should be driven.

Top module: `dac_code_select`

## Requirements
- R1: After reset, the parallel latch and the serial latch both hold 0x80. In parallel mode and in SPI mode the code output is therefore 0x80 until data is committed.
- R2: The mode is decoded with fixed priority. `spi_en_i`=1 selects SPI. Otherwise `cfg_pass_i`=1 selects direct serial. Otherwise `mode_par_i`=1 selects parallel. Otherwise the mode is stored.
- R3: In parallel mode, a rising edge of `cs_i` loads `par_data_i` into the parallel latch, and `dac_code_o` shows it on the third clock edge after the rise reaches the pin.
- R4: In SPI mode, a rising edge of `cs_i` copies the shift register into the serial latch, and `dac_code_o` shows it on the third clock edge after the rise.
- R5: In direct serial mode, a one-cycle `upd_i` pulse copies the shift register into the serial latch at that clock edge. A rising edge of `cs_i` has no effect in this mode, and `upd_i` has no effect in any other mode.
- R6: In stored mode, `dac_code_o` equals `stored_code_i`.
- R7: On each synchronized rising edge of `sclk_i`, the shift register moves left and takes in `sdi_i` at bit 0, so data enters MSB first. `sdo_o` is bit 7, the oldest bit. No shifting happens in parallel mode, or in SPI mode while `cs_i` is high.
- R8: In SPI mode, `sdo_oe_o` is 0 whenever the synchronized `cs_i` is high, and 1 while it is low (unless R9 applies).
- R9: `cfg_sdo_off_i`=1 forces `sdo_oe_o` to 0. In parallel mode `sdo_oe_o` is always 0. In direct and stored modes it is 1 when the disable bit is clear.
- R10: A change on the mode inputs takes effect on the next clock edge. Latch contents survive mode changes.
- R11: The parallel latch changes only on a `cs_i` rise in parallel mode. Bus changes without such a rise, and `cs_i` rises in other modes, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en_i | input | 1 | SPI mode select pin (highest priority) |
| mode_par_i | input | 1 | Parallel mode select pin |
| cfg_pass_i | input | 1 | Configuration bit: direct serial pass-through |
| cfg_sdo_off_i | input | 1 | Configuration bit: disable serial data output |
| cs_i | input | 1 | Chip-select; rising edge commits data |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| par_data_i | input | 8 | Parallel data bus |
| upd_i | input | 1 | Update strobe from the test-access controller, system-clock domain |
| stored_code_i | input | 8 | Code held in nonvolatile storage |
| dac_code_o | output | 8 | Code to the converter |
| sdo_o | output | 1 | Serial data out (oldest shift bit) |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o` |

## Verification
Each asynchronous pin passes through two flip-flop stages and one edge register. A chip-select or serial-clock rise therefore acts on the third clock edge, and its effects on the latches, the code and the output enable are due at that point. A mode change and an `upd_i` pulse act on the first edge. The bench drives inputs on falling edges and counts exactly these edges before it samples. For the chip-select paths it also checks that the code is still the old value after only two edges.

// File: rtl/dac_sel_pkg.sv
package dac_sel_pkg;

  typedef enum logic [1:0] {
    MODE_STORED = 2'd0,
    MODE_PAR    = 2'd1,
    MODE_DIRECT = 2'd2,
    MODE_SPI    = 2'd3
  } dac_mode_e;

  // priority: SPI pin, then pass-through bit, then parallel pin
  function automatic dac_mode_e decode_mode(input logic spi_en,
                                            input logic pass,
                                            input logic par);
    if (spi_en)    return MODE_SPI;
    else if (pass) return MODE_DIRECT;
    else if (par)  return MODE_PAR;
    else           return MODE_STORED;
  endfunction

  // output enable for the serial data pin
  function automatic logic sdo_enable(input dac_mode_e mode,
                                      input logic cs_high,
                                      input logic off);
    case (mode)
      MODE_PAR: return 1'b0;
      MODE_SPI: return !cs_high && !off;
      default:  return !off;
    endcase
  endfunction

endpackage

// File: rtl/dac_sig_sync.sv
module dac_sig_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dac_ser_shift.sv
module dac_ser_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_o <= '0;
    else if (shift_i) sr_o <= {sr_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/dac_code_select.sv
module dac_code_select
  import dac_sel_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en_i,
  input  logic              mode_par_i,
  input  logic              cfg_pass_i,
  input  logic              cfg_sdo_off_i,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [CODE_W-1:0] par_data_i,
  input  logic              upd_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0]  ctl_s;
  logic [CODE_W-1:0] par_s;
  logic              cs_s, sclk_s, sdi_s;
  logic              cs_prev_q, sclk_prev_q;
  logic              cs_rise, sclk_rise;
  dac_mode_e         mode_q;
  logic              shift_en, par_load, ser_load_spi, ser_load_dir;
  logic [CODE_W-1:0] sr_q, par_q, ser_q;

  // synchronizers: control pins idle with chip-select high
  dac_sig_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_i, sclk_i, sdi_i}), .q_o(ctl_s)
  );
  dac_sig_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i(par_data_i), .q_o(par_s)
  );

  assign cs_s   = ctl_s[2];
  assign sclk_s = ctl_s[1];
  assign sdi_s  = ctl_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      mode_q      <= MODE_STORED;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
      mode_q      <= decode_mode(spi_en_i, cfg_pass_i, mode_par_i);
    end
  end

  // named internal events
  assign cs_rise      = cs_s && !cs_prev_q;
  assign sclk_rise    = sclk_s && !sclk_prev_q;
  assign shift_en     = sclk_rise && (mode_q != MODE_PAR) &&
                        !((mode_q == MODE_SPI) && cs_s);
  assign par_load     = cs_rise && (mode_q == MODE_PAR);
  assign ser_load_spi = cs_rise && (mode_q == MODE_SPI);
  assign ser_load_dir = upd_i && (mode_q == MODE_DIRECT);

  dac_ser_shift #(.W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .bit_i(sdi_s), .sr_o(sr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= MID_CODE;
      ser_q <= MID_CODE;
    end else begin
      if (par_load)                     par_q <= par_s;
      if (ser_load_spi || ser_load_dir) ser_q <= sr_q;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_PAR:    dac_code_o = par_q;
      MODE_STORED: dac_code_o = stored_code_i;
      default:     dac_code_o = ser_q;
    endcase
  end

  assign sdo_o    = sr_q[CODE_W-1];
  assign sdo_oe_o = sdo_enable(mode_q, cs_s, cfg_sdo_off_i);

endmodule

// File: rtl/dac_code_select_chk.sv
module dac_code_select_chk
  import dac_sel_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_en_i,
  input logic              cfg_sdo_off_i,
  input logic [CODE_W-1:0] stored_code_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              sdo_oe_o,
  input dac_mode_e         mode_q,
  input logic              cs_s,
  input logic              par_load,
  input logic              ser_load_spi,
  input logic              ser_load_dir,
  input logic [CODE_W-1:0] sr_q,
  input logic [CODE_W-1:0] par_q,
  input logic [CODE_W-1:0] ser_q
);
  AST_SPI_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en_i |=> (mode_q == MODE_SPI)); // R2
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({par_load, ser_load_spi, ser_load_dir})); // R2
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |=> $stable(par_q)); // R11
  AST_SPI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load_spi |=> (ser_q == $past(sr_q))); // R4
  AST_DIR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load_dir |=> (ser_q == $past(sr_q))); // R5
  AST_STORED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STORED) |-> (dac_code_o == stored_code_i)); // R6
  AST_SPI_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_SPI) && cs_s) |-> !sdo_oe_o); // R8
  AST_CFG_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sdo_off_i |-> !sdo_oe_o); // R9
  AST_PAR_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAR) |-> !sdo_oe_o); // R9
endmodule

bind dac_code_select dac_code_select_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_en_i(spi_en_i), .cfg_sdo_off_i(cfg_sdo_off_i),
  .stored_code_i(stored_code_i), .dac_code_o(dac_code_o), .sdo_oe_o(sdo_oe_o),
  .mode_q(mode_q), .cs_s(cs_s), .par_load(par_load), .ser_load_spi(ser_load_spi),
  .ser_load_dir(ser_load_dir), .sr_q(sr_q), .par_q(par_q), .ser_q(ser_q)
);

// File: tb/dac_code_select_tb.sv
module dac_code_select_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_en = 1'b0, mode_par = 1'b0, pass = 1'b0, sdo_off = 1'b0;
  logic       cs = 1'b1, sclk = 1'b0, sdi = 1'b0, upd = 1'b0;
  logic [7:0] par_data = 8'h00, stored = 8'h3C;
  logic [7:0] code;
  logic       sdo, sdo_oe;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dac_code_select dut_i (
    .clk(clk), .rst_n(rst_n), .spi_en_i(spi_en), .mode_par_i(mode_par),
    .cfg_pass_i(pass), .cfg_sdo_off_i(sdo_off), .cs_i(cs), .sclk_i(sclk),
    .sdi_i(sdi), .par_data_i(par_data), .upd_i(upd), .stored_code_i(stored),
    .dac_code_o(code), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // fields: {spi, pass, par, off, cs} expected_oe expected_code
  localparam logic [13:0] VEC [14] = '{
    {5'b10000, 1'b1, 8'h80}, {5'b11100, 1'b1, 8'h80}, {5'b10010, 1'b0, 8'h80},
    {5'b01000, 1'b1, 8'h80}, {5'b01100, 1'b1, 8'h80}, {5'b01010, 1'b0, 8'h80},
    {5'b00100, 1'b0, 8'h80}, {5'b00000, 1'b1, 8'h3C}, {5'b00001, 1'b1, 8'h3C},
    {5'b00011, 1'b0, 8'h3C}, {5'b10001, 1'b0, 8'h80}, {5'b11101, 1'b0, 8'h80},
    {5'b00101, 1'b0, 8'h80}, {5'b01111, 1'b0, 8'h80}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; sclk = 1'b0; tick(3);
    sclk = 1'b1; tick(3);
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic set_mode(input logic s, input logic p, input logic m);
    spi_en = s; pass = p; mode_par = m; tick(1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset contents, parallel then SPI
    set_mode(1'b0, 1'b0, 1'b1); check("R1 par latch", code, 8'h80);
    set_mode(1'b1, 1'b0, 1'b0); check("R1 ser latch", code, 8'h80);

    // R2 R8 R9 R6: mode decode and output enable table
    par_data = 8'hA5;
    foreach (VEC[k]) begin
      {spi_en, pass, mode_par, sdo_off, cs} = VEC[k][13:9];
      tick(4);
      check("R2/R8/R9 oe", {7'd0, sdo_oe}, {7'd0, VEC[k][8]});
      check("R2/R6 code", code, VEC[k][7:0]);
    end
    sdo_off = 1'b0;

    // R3 parallel capture on cs rise
    set_mode(1'b0, 1'b0, 1'b1);
    cs = 1'b0; tick(4);
    cs = 1'b1; tick(2);
    check("R3 not yet", code, 8'h80);
    tick(1);
    check("R3 loaded", code, 8'hA5);
    par_data = 8'h11; tick(5);
    check("R11 bus ignored", code, 8'hA5);
    // R10: mode change next edge, contents kept
    set_mode(1'b1, 1'b0, 1'b1); check("R10 to spi", code, 8'h80);
    set_mode(1'b0, 1'b0, 1'b1); check("R10 back par", code, 8'hA5);

    // R4 R7 R8 SPI
    set_mode(1'b1, 1'b0, 1'b0);
    cs = 1'b0; tick(4);
    shift_byte(8'hC6);
    check("R7 msb first sdo", {7'd0, sdo}, 8'h01);
    check("R8 oe cs low", {7'd0, sdo_oe}, 8'h01);
    check("R4 before cs", code, 8'h80);
    cs = 1'b1; tick(2);
    check("R4 not yet", code, 8'h80);
    tick(1);
    check("R4 committed", code, 8'hC6);
    check("R8 oe cs high", {7'd0, sdo_oe}, 8'h00);

    // R5 direct serial
    set_mode(1'b0, 1'b1, 1'b0);
    cs = 1'b0; tick(4);
    shift_byte(8'h5B);
    check("R7 sdo after byte", {7'd0, sdo}, 8'h00);
    shift_bit(1'b0);
    check("R7 sdo oldest bit", {7'd0, sdo}, 8'h01);
    cs = 1'b1; tick(5);
    check("R5 cs ignored", code, 8'hC6);
    upd = 1'b1; tick(1); upd = 1'b0;
    check("R5 upd commit", code, 8'hB6);
    shift_bit(1'b1);
    set_mode(1'b1, 1'b0, 1'b0);
    upd = 1'b1; tick(1); upd = 1'b0; tick(1);
    check("R5 upd ignored in spi", code, 8'hB6);

    // R11 parallel latch untouched by SPI cs rise
    set_mode(1'b0, 1'b0, 1'b1);
    check("R11 par kept", code, 8'hA5);

    // R6 stored
    stored = 8'h77;
    set_mode(1'b0, 1'b0, 1'b0); check("R6 stored", code, 8'h77);
    stored = 8'h78; tick(1); check("R6 stored follows", code, 8'h78);

    // R1 reset mid-run
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
    set_mode(1'b0, 1'b0, 1'b1); check("R1 par after reset", code, 8'h80);
    set_mode(1'b1, 1'b0, 1'b0); check("R1 ser after reset", code, 8'h80);

    done = 1'b1;
    summary();
  end
endmodule